// File: doc/BRIEF.md
# Transmit Packet Queue Loader

The block sits between a 64-bit burst-oriented host write bus and one transmit port's packet queue. The host writes words with an active-low byte-enable mask. It frames each packet with a start marker on the first word and an end marker on the last. The loader checks that the enabled lanes of each word form one contiguous run. It shifts those bytes down and appends them to a packing accumulator. Each time eight bytes have gathered, it stores a full 64-bit entry. The tail of a packet is stored with its byte count and a last flag. Two per-packet attributes travel with the entries. The raw-frame flag means no padding and no checksum append. It is set by a global configuration bit or by the raw input sampled with the start marker. The error flag is sampled with the end marker and is carried on the last entry.

The queue side shows its head entry whenever the queue is not empty, and a read strobe removes that entry. The host side sees a ready flag. It is high when the free entries reach a programmable threshold, the control strobe enables the flag, and the port is not being selected. A single-packet option stops a second packet from entering until the stored one has drained.

Control is an enumerated state machine with three states. `ST_IDLE` waits for a start marker. `ST_LOAD` is inside a packet. `ST_HOLD` is used only in single-packet mode and waits for the queue to empty. The transitions are:
- IDLE→LOAD on an accepted start word without an end marker.
- IDLE→IDLE or IDLE→HOLD on an accepted start+end word.
- LOAD→LOAD on any accepted word without an end marker, including a restart.
- LOAD→IDLE, or LOAD→HOLD in single-packet mode, on an accepted end word.
- HOLD→IDLE once the queue count is zero.

Top module: `txq_load`

## Requirements
- R1: After reset the queue is empty (`rd_valid` low), both sticky flags are low and the state is idle.
- R2: With `ctl_n` low, `sel_n` high and the block not holding, `rdy` is high exactly when the free entries (DEPTH minus stored entries) are at least `cfg_thresh`.
- R3: `rdy_oe` equals the inverse of `ctl_n`. While `ctl_n` is high, `rdy` is low.
- R4: While `sel_n` is low and `port_hit` is high, `rdy` is low.
- R5: Byte lane i is `wr_data[8i+7:8i]`, and an enable is a 0 in `wr_be_n`. The enabled bytes, lowest lane first, are appended in write order. Entries hold packet bytes in order, with the first byte in bits 7:0. Bytes above an entry's count are zero.
- R6: Every entry except the last of a packet has count 8 and last flag 0. The last entry has last flag 1 and a count from 1 to 8, so a packet of L bytes gives ceil(L/8) entries.
- R7: Every entry of a packet carries raw flag = `cfg_nocrc` OR `wr_asis`, both sampled on the start word.
- R8: The last entry carries the error flag equal to `wr_err` on the end word. Other entries carry 0.
- R9: A word is dropped and sets the sticky `proto_flag` if its mask has no enabled lane or non-contiguous enabled lanes, or if it has no start marker while no packet is open.
- R10: A well-formed word that needs more entries than are free is dropped and sets the sticky `ovf_flag`. An end word whose bytes cross an entry boundary needs two entries; such a word is stored whole.
- R11: With `cfg_single` high, after an accepted end word `rdy` stays low and new start words are dropped as in R10. This lasts until the queue has drained; the cycle after it empties, normal ready returns.
- R12: `rd_valid` is high when the queue is not empty. `rd_en` removes the head entry, and entries leave in the order they were stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_thresh | input | AW+1 | Free-entry threshold for ready |
| cfg_nocrc | input | 1 | Global raw-frame configuration |
| cfg_single | input | 1 | Single-packet mode |
| ctl_n | input | 1 | Active-low ready enable strobe |
| sel_n | input | 1 | Active-low port select strobe |
| port_hit | input | 1 | This port is the selected one |
| rdy | output | 1 | Space ready flag |
| rdy_oe | output | 1 | Ready flag output enable |
| wr_valid | input | 1 | Host write strobe |
| wr_data | input | 64 | Host write word |
| wr_be_n | input | 8 | Active-low byte enables |
| wr_sop | input | 1 | Start of packet |
| wr_eop | input | 1 | End of packet |
| wr_asis | input | 1 | Raw-frame request (with start) |
| wr_err | input | 1 | Error request (with end) |
| rd_en | input | 1 | Remove head entry |
| rd_valid | output | 1 | Head entry present |
| rd_data | output | 64 | Head entry data |
| rd_nbytes | output | 4 | Valid bytes in head entry |
| rd_last | output | 1 | Head is last entry of a packet |
| rd_asis | output | 1 | Head packet is raw |
| rd_err | output | 1 | Head packet ends in error |
| ovf_flag | output | 1 | Sticky overflow |
| proto_flag | output | 1 | Sticky protocol error |

## Verification
The bench builds the loader with DEPTH = 8 (AW = 3), so the threshold covers every value from 0 to the full queue. At this depth, a packet of nine full words overflows the queue, and random packets of up to 24 bytes keep several packets queued at once. This small depth also lets single-packet mode drain and re-arm in a few cycles. The default depth of 16 changes only the counter widths.

// File: rtl/txq_pkg.sv
package txq_pkg;
    localparam int LANES  = 8;
    localparam int WORD_W = 8 * LANES;
    localparam int CNT_W  = $clog2(LANES) + 1;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [CNT_W-1:0]  nbytes;
        logic              last;
        logic              asis;
        logic              err;
    } txq_ent_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_HOLD = 2'd2
    } txq_st_e;
endpackage

// File: rtl/txq_lane_pack.sv
module txq_lane_pack
    import txq_pkg::*;
(
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [LANES-1:0]    wr_be_n,
    input  logic [WORD_W-1:0]   acc,
    input  logic [CNT_W-1:0]    acc_cnt,
    output logic                legal,
    output logic [2*WORD_W-1:0] cat,
    output logic [CNT_W:0]      total
);
    logic [LANES-1:0]  en;
    logic [CNT_W-1:0]  lo, hi, pop;
    logic              found;
    logic [WORD_W-1:0] shifted;

    always_comb begin
        en    = ~wr_be_n;
        lo    = '0;
        hi    = '0;
        pop   = '0;
        found = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (en[i]) begin
                if (!found) lo = CNT_W'(i);
                found = 1'b1;
                hi    = CNT_W'(i);
                pop   = pop + 1'b1;
            end
        end
        legal   = found && (pop == (hi - lo + 1'b1));
        shifted = wr_data >> {lo, 3'b000};
        for (int i = 0; i < LANES; i++) begin
            if (CNT_W'(i) >= pop) shifted[8*i +: 8] = 8'h00;
        end
        cat   = {{WORD_W{1'b0}}, acc} | ({{WORD_W{1'b0}}, shifted} << {acc_cnt, 3'b000});
        total = {1'b0, acc_cnt} + {1'b0, pop};
    end
endmodule

// File: rtl/txq_store.sv
module txq_store
    import txq_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  push_n,
    input  txq_ent_t    e0,
    input  txq_ent_t    e1,
    input  logic        pop,
    output txq_ent_t    head,
    output logic [AW:0] count
);
    txq_ent_t        mem [DEPTH];
    logic [AW-1:0]   wp, rp;
    logic            pop_ok;

    assign pop_ok = pop && (count != '0);
    assign head   = mem[rp];

    always_ff @(posedge clk) begin
        if (push_n != 2'd0) mem[wp] <= e0;
        if (push_n == 2'd2) mem[wp + 1'b1] <= e1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            wp    <= wp + AW'(push_n);
            rp    <= rp + AW'(pop_ok);
            count <= count + (AW+1)'(push_n) - (AW+1)'(pop_ok);
        end
    end

    assert_fill_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= (AW+1)'(DEPTH));
    assert_no_underflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && push_n == 2'd0) |=> count == '0);
endmodule

// File: rtl/txq_load.sv
module txq_load
    import txq_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW:0]       cfg_thresh,
    input  logic              cfg_nocrc,
    input  logic              cfg_single,
    input  logic              ctl_n,
    input  logic              sel_n,
    input  logic              port_hit,
    output logic              rdy,
    output logic              rdy_oe,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_be_n,
    input  logic              wr_sop,
    input  logic              wr_eop,
    input  logic              wr_asis,
    input  logic              wr_err,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic [CNT_W-1:0]  rd_nbytes,
    output logic              rd_last,
    output logic              rd_asis,
    output logic              rd_err,
    output logic              ovf_flag,
    output logic              proto_flag
);
    txq_st_e             state, state_nx;
    logic [WORD_W-1:0]   acc, acc_eff;
    logic [CNT_W-1:0]    acc_cnt, cnt_eff;
    logic                asis_r, asis_cur;
    logic                legal, framed, room, take, ovf_hit, bad;
    logic [2*WORD_W-1:0] cat;
    logic [CNT_W:0]      total;
    logic [1:0]          need_n, push_n;
    logic [AW:0]         count, free;
    txq_ent_t            e0, e1, head;

    assign acc_eff = wr_sop ? '0 : acc;
    assign cnt_eff = wr_sop ? '0 : acc_cnt;

    txq_lane_pack u_pack (
        .wr_data (wr_data),
        .wr_be_n (wr_be_n),
        .acc     (acc_eff),
        .acc_cnt (cnt_eff),
        .legal   (legal),
        .cat     (cat),
        .total   (total)
    );

    txq_store #(.DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_n (push_n),
        .e0     (e0),
        .e1     (e1),
        .pop    (rd_en),
        .head   (head),
        .count  (count)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (take) state_nx = wr_eop ? (cfg_single ? ST_HOLD : ST_IDLE) : ST_LOAD;
            ST_LOAD: if (take && wr_eop) state_nx = cfg_single ? ST_HOLD : ST_IDLE;
            ST_HOLD: if (count == '0) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs and write-side decisions
    always_comb begin
        asis_cur = wr_sop ? (wr_asis | cfg_nocrc) : asis_r;
        free     = (AW+1)'(DEPTH) - count;
        e0       = '0;
        e1       = '0;
        need_n   = 2'd0;
        if (total >= (CNT_W+1)'(LANES)) begin
            need_n    = 2'd1;
            e0.data   = cat[WORD_W-1:0];
            e0.nbytes = CNT_W'(LANES);
            e0.last   = wr_eop && (total == (CNT_W+1)'(LANES));
            if (wr_eop && total > (CNT_W+1)'(LANES)) begin
                need_n    = 2'd2;
                e1.data   = cat[2*WORD_W-1:WORD_W];
                e1.nbytes = CNT_W'(total - (CNT_W+1)'(LANES));
                e1.last   = 1'b1;
            end
        end else if (wr_eop) begin
            need_n    = 2'd1;
            e0.data   = cat[WORD_W-1:0];
            e0.nbytes = total[CNT_W-1:0];
            e0.last   = 1'b1;
        end
        e0.asis  = asis_cur;
        e1.asis  = asis_cur;
        e0.err   = e0.last && wr_err;
        e1.err   = e1.last && wr_err;
        framed   = wr_sop || (state == ST_LOAD);
        room     = (state != ST_HOLD) && (free >= (AW+1)'(need_n));
        bad      = wr_valid && (!legal || !framed);
        take     = wr_valid && legal && framed && room;
        ovf_hit  = wr_valid && legal && framed && !room;
        push_n   = take ? need_n : 2'd0;
        rdy_oe   = !ctl_n;
        rdy      = rdy_oe && (state != ST_HOLD) && (free >= cfg_thresh) && !(!sel_n && port_hit);
        rd_valid  = (count != '0);
        rd_data   = head.data;
        rd_nbytes = head.nbytes;
        rd_last   = head.last;
        rd_asis   = head.asis;
        rd_err    = head.err;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc        <= '0;
            acc_cnt    <= '0;
            asis_r     <= 1'b0;
            ovf_flag   <= 1'b0;
            proto_flag <= 1'b0;
        end else begin
            if (ovf_hit) ovf_flag   <= 1'b1;
            if (bad)     proto_flag <= 1'b1;
            if (take) begin
                asis_r <= asis_cur;
                if (wr_eop) begin
                    acc     <= '0;
                    acc_cnt <= '0;
                end else if (total >= (CNT_W+1)'(LANES)) begin
                    acc     <= cat[2*WORD_W-1:WORD_W];
                    acc_cnt <= CNT_W'(total - (CNT_W+1)'(LANES));
                end else begin
                    acc     <= cat[WORD_W-1:0];
                    acc_cnt <= total[CNT_W-1:0];
                end
            end
        end
    end

    assert_rdy_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_n |-> !rdy);
    assert_select_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && port_hit) |-> !rdy);
    assert_mid_entry_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_n != 2'd0 && !e0.last) |-> e0.nbytes == CNT_W'(LANES));
    assert_proto_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        proto_flag |=> proto_flag);
    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);
    assert_hold_rejects_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && wr_valid && wr_sop && legal) |=> ovf_flag);
endmodule

// File: tb/test_txq_load.sv
module test_txq_load;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int AW         = 3;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [AW:0] cfg_thresh = '0;
    logic        cfg_nocrc = 0, cfg_single = 0, ctl_n = 0, sel_n = 1, port_hit = 0;
    logic        rdy, rdy_oe;
    logic        wr_valid = 0, wr_sop = 0, wr_eop = 0, wr_asis = 0, wr_err = 0;
    logic [63:0] wr_data = '0;
    logic [7:0]  wr_be_n = 8'hFF;
    logic        rd_en = 0, rd_valid, rd_last, rd_asis, rd_err, ovf_flag, proto_flag;
    logic [63:0] rd_data;
    logic [3:0]  rd_nbytes;

    txq_load #(.DEPTH(DEPTH)) i_txq_load (
        .clk(clk), .rst_n(rst_n), .cfg_thresh(cfg_thresh), .cfg_nocrc(cfg_nocrc),
        .cfg_single(cfg_single), .ctl_n(ctl_n), .sel_n(sel_n), .port_hit(port_hit),
        .rdy(rdy), .rdy_oe(rdy_oe), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_be_n(wr_be_n), .wr_sop(wr_sop), .wr_eop(wr_eop), .wr_asis(wr_asis),
        .wr_err(wr_err), .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_nbytes(rd_nbytes), .rd_last(rd_last), .rd_asis(rd_asis), .rd_err(rd_err),
        .ovf_flag(ovf_flag), .proto_flag(proto_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;
    logic [7:0]  pb[$];
    logic [63:0] ed[$];
    int          en_q[$];
    bit          el[$], ea[$], ee[$];
    bit          cur_asis;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_rdy(int free, int th, logic ctl, logic sel, logic hit, logic hold);
        return !ctl && !hold && (free >= th) && !(!sel && hit);
    endfunction

    function automatic logic [7:0] mask_of(int lo, int n);
        return ~(8'((1 << n) - 1) << lo);
    endfunction

    task automatic build(bit err);
        int m = pb.size();
        int idx = 0;
        while (idx < m) begin
            int cnt = (m - idx > 8) ? 8 : m - idx;
            logic [63:0] d = '0;
            for (int b = 0; b < cnt; b++) d[8*b +: 8] = pb[idx + b];
            ed.push_back(d);
            en_q.push_back(cnt);
            el.push_back(idx + cnt == m);
            ea.push_back(cur_asis);
            ee.push_back((idx + cnt == m) ? err : 1'b0);
            idx += cnt;
        end
    endtask

    task automatic raw(logic [63:0] d, logic [7:0] be, bit sop, bit eop);
        wr_data = d; wr_be_n = be; wr_sop = sop; wr_eop = eop; wr_valid = 1;
        @(posedge clk); @(negedge clk);
        wr_valid = 0; wr_sop = 0; wr_eop = 0; wr_asis = 0; wr_err = 0;
    endtask

    task automatic word(int lo, int n, bit sop, bit eop, bit asis, bit err);
        logic [63:0] d = {$urandom, $urandom};
        if (sop) begin pb.delete(); cur_asis = asis | cfg_nocrc; end
        for (int k = 0; k < n; k++) pb.push_back(d[8*(lo+k) +: 8]);
        if (eop) build(err);
        wr_asis = asis; wr_err = err;
        raw(d, mask_of(lo, n), sop, eop);
    endtask

    task automatic drain_one();
        chk("R12 rd_valid", rd_valid, 1);
        chk("R5 data", rd_data, ed.pop_front());
        chk("R6 nbytes", rd_nbytes, en_q.pop_front());
        chk("R6 last", rd_last, el.pop_front());
        chk("R7 asis", rd_asis, ea.pop_front());
        chk("R8 err", rd_err, ee.pop_front());
        rd_en = 1; @(posedge clk); @(negedge clk); rd_en = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; ed.delete(); en_q.delete(); el.delete(); ea.delete(); ee.delete();
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1;
    endtask

    task automatic summary();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        cfg_thresh = 1;
        do_reset();
        // R1 reset state
        chk("R1 rd_valid", rd_valid, 0);
        chk("R1 ovf", ovf_flag, 0);
        chk("R1 proto", proto_flag, 0);
        chk("R1 rdy", rdy, 1);

        // random packets: R2..R8, R12
        for (int p = 0; p < 60; p++) begin
            int rem = 1 + $urandom % 24;
            bit first = 1;
            bit asis = $urandom % 2;
            bit err = $urandom % 2;
            cfg_nocrc = $urandom % 2;
            while (rem > 0) begin
                int lo = $urandom % 8;
                int n = 1 + $urandom % (8 - lo);
                if (n > rem) n = rem;
                rem -= n;
                word(lo, n, first, rem == 0, asis, err);
                first = 0;
            end
            cfg_thresh = 4'($urandom % 9);
            ctl_n = ($urandom % 4) == 0;
            sel_n = ($urandom % 3) != 0;
            port_hit = $urandom % 2;
            #1;
            chk("R3 rdy_oe", rdy_oe, !ctl_n);
            chk("R2/R4 rdy", rdy, exp_rdy(DEPTH - ed.size(), cfg_thresh, ctl_n, sel_n, port_hit, 0));
            @(negedge clk);
            ctl_n = 0; sel_n = 1; port_hit = 0;
            if (ed.size() >= 5) while (ed.size() > 0) drain_one();
        end
        while (ed.size() > 0) drain_one();
        chk("R12 empty", rd_valid, 0);
        chk("R10 no ovf", ovf_flag, 0);

        // double push on end word: 7 bytes then 8 bytes
        cfg_nocrc = 0;
        word(0, 7, 1, 0, 1, 0);
        word(0, 8, 0, 1, 0, 1);
        chk("R10 two entries stored", ed.size(), 2);
        while (ed.size() > 0) drain_one();
        chk("R12 empty after pair", rd_valid, 0);

        // R9 non-contiguous mask
        raw(64'h1122334455667788, 8'b1111_1010, 1, 1);
        chk("R9 proto noncontig", proto_flag, 1);
        chk("R9 dropped", rd_valid, 0);
        do_reset();
        raw(64'h0102030405060708, 8'h00, 0, 1);
        chk("R9 proto unframed", proto_flag, 1);
        chk("R9 unframed dropped", rd_valid, 0);
        chk("R9 not ovf", ovf_flag, 0);
        do_reset();

        // R10 overflow
        cfg_thresh = 0;
        for (int i = 0; i < 9; i++) raw({$urandom, $urandom}, 8'h00, i == 0, 0);
        chk("R10 ovf set", ovf_flag, 1);
        begin
            int got = 0;
            while (rd_valid && got < 20) begin
                got++;
                rd_en = 1; @(posedge clk); @(negedge clk); rd_en = 0;
            end
            chk("R10 stored count", got, 8);
        end
        do_reset();

        // R11 single-packet mode
        cfg_single = 1; cfg_thresh = 1;
        word(2, 3, 1, 1, 0, 0);
        chk("R11 rdy held", rdy, 0);
        raw(64'hAAAA, 8'h00, 1, 1);
        chk("R11 second packet refused", ovf_flag, 1);
        drain_one();
        chk("R11 queue empty", rd_valid, 0);
        chk("R11 still held", rdy, 0);
        @(posedge clk); @(negedge clk);
        chk("R11 ready returns", rdy, 1);
        cfg_single = 0;
        summary();
    end
endmodule